// File: doc/BRIEF.md
# Load/Store Address Generator

This block computes the memory address for word and unsigned-byte load/store operations, along with the update for the base register. The offset comes from one of three sources: a zero-extended 12-bit immediate, a register value, or a register value shifted by a 5-bit immediate amount. A direction bit chooses whether the offset is added to the base or subtracted from it. All arithmetic wraps modulo 2^32.

There are three indexing modes. In offset mode the block only forms an address. In pre-indexed mode it forms an address and also writes that address back into the base. In post-indexed mode it accesses the unmodified base and writes back base ± offset. Writeback happens only when the instruction's condition passed.

For FPGA timing, every output is registered once. A set of operands presented before a rising clock edge appears on the outputs just after that edge. The reset is synchronous and active-high.

Top module: `ls_agu`

## Requirements
- R1: While `rst` is high at a rising edge, `mem_addr`, `wb_en` and `wb_val` are cleared to zero at that edge.
- R2: When `use_reg` is 0, the offset is `imm_ofs` zero-extended to 32 bits, and `shift_kind`, `shift_amt` and `carry_in` have no effect on any output.
- R3: When `add_dir` is 1 the offset is added to `base_val`; when it is 0 the offset is subtracted. Both results wrap modulo 2^32.
- R4: With `use_reg` 1 and `shift_kind` 0 (logical left), the index is `reg_val` shifted left by `shift_amt`. An amount of 0 passes `reg_val` through unchanged, which gives the plain-register offset.
- R5: With `shift_kind` 1 (logical right), the index is `reg_val` shifted right by `shift_amt`. An amount of 0 means a shift by 32, so the index is zero.
- R6: With `shift_kind` 2 (arithmetic right), the index is `reg_val` shifted right with its sign bit copied in. An amount of 0 means a shift by 32: the index is all ones if bit 31 of `reg_val` is set, and zero otherwise.
- R7: With `shift_kind` 3 and a nonzero amount, the index is `reg_val` rotated right by `shift_amt`. With amount 0, the index is `carry_in` in bit 31 above bits 31..1 of `reg_val`.
- R8: When `idx_mode` is 0 (offset), or 3 (also treated as offset), `mem_addr` is base ± offset and `wb_en` is 0.
- R9: When `idx_mode` is 1 (pre-indexed), `mem_addr` is base ± offset, `wb_en` equals `cond_ok`, and when `wb_en` is 1, `wb_val` equals `mem_addr`.
- R10: When `idx_mode` is 2 (post-indexed), `mem_addr` is `base_val` unchanged, `wb_en` equals `cond_ok`, and when `wb_en` is 1, `wb_val` is base ± offset.
- R11: Outputs have a latency of exactly one clock. The values after a rising edge depend only on the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_val | input | 32 | Base register value |
| reg_val | input | 32 | Index register value |
| imm_ofs | input | 12 | Unsigned immediate offset |
| use_reg | input | 1 | 1 = register-derived offset, 0 = immediate |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR/RRX |
| shift_amt | input | 5 | Shift amount |
| add_dir | input | 1 | 1 = add offset, 0 = subtract |
| carry_in | input | 1 | Carry flag, used by the rotate-extended case |
| cond_ok | input | 1 | Condition-passed indication |
| idx_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 treated as offset |
| mem_addr | output | 32 | Registered access address |
| wb_en | output | 1 | Registered base writeback enable |
| wb_val | output | 32 | Registered base writeback value |

## Verification
The bench targets the zero-amount encodings, because a design that shifts literally by zero there returns `reg_val` instead of zero, the sign fill, or the carry-fed rotate. It drives operands that wrap past 0 and past 2^32, which catches adders that saturate or drop the borrow. Writeback is tested with the condition both passed and failed in every mode. A design that writes back in offset mode, or ignores `cond_ok`, fails these cases. So does one that swaps the pre-indexed and post-indexed address choice, which shows up as a wrong address or a wrong update value.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    IX_OFFSET = 2'd0,
    IX_PRE    = 2'd1,
    IX_POST   = 2'd2,
    IX_RSVD   = 2'd3
  } idx_mode_e;
endpackage

// File: rtl/agu_index_shift.sv
module agu_index_shift #(
  parameter int W    = 32,
  parameter int AMTW = $clog2(W)
) (
  input  logic [W-1:0]    val,
  input  logic [1:0]      kind,
  input  logic [AMTW-1:0] amt,
  input  logic            cin,
  output logic [W-1:0]    res
);
  import agu_pkg::*;

  logic [2*W-1:0] dbl;
  logic [2*W-1:0] dbl_sh;
  logic           amt_zero;

  assign amt_zero = (amt == '0);
  assign dbl      = {val, val};
  assign dbl_sh   = dbl >> amt;

  always_comb begin
    unique case (shift_kind_e'(kind))
      SH_LSL: res = val << amt;
      SH_LSR: res = amt_zero ? '0 : (val >> amt);
      SH_ASR: res = amt_zero ? {W{val[W-1]}} : W'($signed(val) >>> amt);
      SH_ROR: res = amt_zero ? {cin, val[W-1:1]} : dbl_sh[W-1:0];
      default: res = val;
    endcase
  end
endmodule

// File: rtl/agu_offset_mux.sv
module agu_offset_mux #(
  parameter int W    = 32,
  parameter int IMMW = 12
) (
  input  logic            use_reg,
  input  logic [IMMW-1:0] imm,
  input  logic [W-1:0]    idx,
  output logic [W-1:0]    ofs
);
  localparam int PADW = W - IMMW;

  always_comb begin
    if (use_reg) ofs = idx;
    else         ofs = {{PADW{1'b0}}, imm};
  end
endmodule

// File: rtl/agu_sum.sv
module agu_sum #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] ofs,
  input  logic         up,
  output logic [W-1:0] sum
);
  logic [W-1:0] ofs_eff;
  logic [W-1:0] cin_vec;

  assign ofs_eff = up ? ofs : ~ofs;
  assign cin_vec = {{(W-1){1'b0}}, ~up};
  assign sum     = base + ofs_eff + cin_vec;
endmodule

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int W    = 32,
  parameter int IMMW = 12,
  parameter int AMTW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    base_val,
  input  logic [W-1:0]    reg_val,
  input  logic [IMMW-1:0] imm_ofs,
  input  logic            use_reg,
  input  logic [1:0]      shift_kind,
  input  logic [AMTW-1:0] shift_amt,
  input  logic            add_dir,
  input  logic            carry_in,
  input  logic            cond_ok,
  input  logic [1:0]      idx_mode,
  output logic [W-1:0]    mem_addr,
  output logic            wb_en,
  output logic [W-1:0]    wb_val
);
  import agu_pkg::*;

  logic [W-1:0] idx_w;
  logic [W-1:0] ofs_w;
  logic [W-1:0] target_w;
  logic [W-1:0] addr_d;
  logic         wb_en_d;
  idx_mode_e    mode;

  assign mode = idx_mode_e'(idx_mode);

  agu_index_shift #(.W(W), .AMTW(AMTW)) u_shift (
    .val(reg_val), .kind(shift_kind), .amt(shift_amt), .cin(carry_in), .res(idx_w)
  );

  agu_offset_mux #(.W(W), .IMMW(IMMW)) u_mux (
    .use_reg(use_reg), .imm(imm_ofs), .idx(idx_w), .ofs(ofs_w)
  );

  agu_sum #(.W(W)) u_sum (
    .base(base_val), .ofs(ofs_w), .up(add_dir), .sum(target_w)
  );

  always_comb begin
    addr_d  = (mode == IX_POST) ? base_val : target_w;
    wb_en_d = cond_ok && ((mode == IX_PRE) || (mode == IX_POST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      wb_en    <= 1'b0;
      wb_val   <= '0;
    end else begin
      mem_addr <= addr_d;
      wb_en    <= wb_en_d;
      wb_val   <= target_w;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0 && !wb_en && wb_val == '0));

  assert_lsr_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_kind == 2'd1 && shift_amt == '0) |-> (idx_w == '0));

  assert_rrx_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (shift_kind == 2'd3 && shift_amt == '0) |-> (idx_w[W-1] == carry_in));

  assert_offset_no_wb_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(idx_mode) == 2'd0 || $past(idx_mode) == 2'd3)) |-> !wb_en);

  assert_pre_wb_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(idx_mode) == 2'd1 && $past(cond_ok)) |-> (wb_en && wb_val == mem_addr));

  assert_post_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(idx_mode) == 2'd2) |-> (mem_addr == $past(base_val) && wb_en == $past(cond_ok)));
endmodule

// File: tb/sim_ls_agu.sv
`timescale 1ns/1ps
module sim_ls_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] base_val = '0, reg_val = '0;
  logic [11:0] imm_ofs = '0;
  logic        use_reg = 1'b0, add_dir = 1'b1, carry_in = 1'b0, cond_ok = 1'b0;
  logic [1:0]  shift_kind = '0, idx_mode = '0;
  logic [4:0]  shift_amt = '0;
  logic [31:0] mem_addr, wb_val;
  logic        wb_en;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ls_agu u0 (
    .clk(clk), .rst(rst), .base_val(base_val), .reg_val(reg_val), .imm_ofs(imm_ofs),
    .use_reg(use_reg), .shift_kind(shift_kind), .shift_amt(shift_amt), .add_dir(add_dir),
    .carry_in(carry_in), .cond_ok(cond_ok), .idx_mode(idx_mode),
    .mem_addr(mem_addr), .wb_en(wb_en), .wb_val(wb_val)
  );

  function automatic logic [31:0] ref_index(logic [31:0] v, int kind, int amt, logic c);
    logic [31:0] r;
    r = v;
    case (kind)
      0: for (int i = 0; i < amt; i++) r = {r[30:0], 1'b0};
      1: begin
        int n = (amt == 0) ? 32 : amt;
        for (int i = 0; i < n; i++) r = {1'b0, r[31:1]};
      end
      2: begin
        int n = (amt == 0) ? 32 : amt;
        for (int i = 0; i < n; i++) r = {v[31], r[31:1]};
      end
      default: begin
        if (amt == 0) r = {c, v[31:1]};
        else for (int i = 0; i < amt; i++) r = {r[0], r[31:1]};
      end
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] ea, logic ew, logic [31:0] ev);
    tests++;
    if (mem_addr !== ea || wb_en !== ew || (ew && wb_val !== ev)) begin
      fails++;
      $display("FAIL %s: addr=%h wb_en=%b wb_val=%h expected addr=%h wb_en=%b wb_val=%h",
               tag, mem_addr, wb_en, wb_val, ea, ew, ev);
    end
  endtask

  // Drive one operand set, then compare for two clocks (latency and hold).
  task automatic vec(string tag, logic [31:0] b, logic [31:0] rv, logic [11:0] im, logic ur,
                     int kind, int amt, logic up, logic c, logic co, int mode);
    longint t;
    logic [31:0] ofs, tgt, ea;
    logic ew;
    @(negedge clk);
    base_val = b; reg_val = rv; imm_ofs = im; use_reg = ur; shift_kind = 2'(kind);
    shift_amt = 5'(amt); add_dir = up; carry_in = c; cond_ok = co; idx_mode = 2'(mode);
    ofs = ur ? ref_index(rv, kind, amt, c) : {20'd0, im};
    t = up ? (longint'(b) + longint'(ofs)) : (longint'(b) - longint'(ofs));
    tgt = t[31:0];
    ea = (mode == 2) ? b : tgt;
    ew = co && (mode == 1 || mode == 2);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(tag, ea, ew, tgt);
    end
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 32'h0);
    @(negedge clk); rst = 1'b0;
    // R2 immediate, shift fields must be ignored
    vec("R2 imm", 32'h1000, 32'hFFFF_FFFF, 12'hFFF, 0, 3, 0, 1, 1, 0, 0);
    vec("R2 imm ign", 32'h1000, 32'h1234_5678, 12'h004, 0, 2, 7, 1, 0, 0, 0);
    // R3 wrap
    vec("R3 add wrap", 32'hFFFF_FFF0, 32'h0, 12'h020, 0, 0, 0, 1, 0, 0, 0);
    vec("R3 sub wrap", 32'h0000_0004, 32'h0, 12'h008, 0, 0, 0, 0, 0, 0, 0);
    // R4
    vec("R4 lsl0", 32'h100, 32'h8000_0001, 12'h0, 1, 0, 0, 1, 0, 0, 0);
    vec("R4 lsl", 32'h100, 32'h0000_0003, 12'h0, 1, 0, 31, 1, 0, 0, 0);
    // R5
    vec("R5 lsr0", 32'h500, 32'hFFFF_FFFF, 12'h0, 1, 1, 0, 1, 0, 0, 0);
    vec("R5 lsr", 32'h500, 32'hF000_0000, 12'h0, 1, 1, 4, 0, 0, 0, 0);
    // R6
    vec("R6 asr0 neg", 32'h10, 32'h8000_0000, 12'h0, 1, 2, 0, 1, 0, 0, 0);
    vec("R6 asr0 pos", 32'h10, 32'h7FFF_FFFF, 12'h0, 1, 2, 0, 1, 0, 0, 0);
    vec("R6 asr", 32'h10, 32'h8000_0100, 12'h0, 1, 2, 8, 1, 0, 0, 0);
    // R7
    vec("R7 rrx c1", 32'h0, 32'h0000_0003, 12'h0, 1, 3, 0, 1, 1, 0, 0);
    vec("R7 rrx c0", 32'h0, 32'h8000_0003, 12'h0, 1, 3, 0, 1, 0, 0, 0);
    vec("R7 ror", 32'h0, 32'h0000_00F1, 12'h0, 1, 3, 4, 1, 1, 0, 0);
    // R8 offset modes with cond passed
    vec("R8 offset", 32'h2000, 32'h0, 12'h010, 0, 0, 0, 1, 0, 1, 0);
    vec("R8 mode3", 32'h2000, 32'h0, 12'h010, 0, 0, 0, 0, 0, 1, 3);
    // R9 pre
    vec("R9 pre pass", 32'h3000, 32'h40, 12'h0, 1, 0, 2, 1, 0, 1, 1);
    vec("R9 pre fail", 32'h3000, 32'h40, 12'h0, 1, 0, 2, 0, 0, 0, 1);
    // R10 post
    vec("R10 post pass", 32'h4000, 32'h0, 12'h123, 0, 0, 0, 0, 0, 1, 2);
    vec("R10 post fail", 32'h4000, 32'h0, 12'h123, 0, 0, 0, 1, 0, 0, 2);
    // R11 random sweep, compared every clock
    for (int i = 0; i < 300; i++)
      vec("R11 rand", $urandom, $urandom, 12'($urandom), 1'($urandom), int'($urandom % 4),
          int'($urandom % 32), 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4));
    // R1 reset again mid-run
    @(negedge clk); idx_mode = 2'd1; cond_ok = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", 32'h0, 1'b0, 32'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule